// File: doc/BRIEF.md
# Supply-Aware Memory Strobe Guard

The guard sits between a host and a byte-wide static RAM array. It passes the host's chip-enable, output-enable and write-enable strobes through to the array while the supply is healthy. It closes them when two external comparator flags report a failing supply. One flag says the supply is below the deselect threshold. The other says the supply is below the battery switchover threshold.

When the supply fails, an access the host marks as in progress may finish. It has a bounded grace window of `TWP` clock cycles to do so. After that window, write protection is forced. Below the switchover threshold the guard asserts a battery-select output, which moves retention power to the internal source.

When the supply comes back, protection stays on for `TER` further cycles so that the host can settle. The battery path stays isolated after reset until external power has been seen once. Both comparator flags pass through two flip-flops before the controller uses them. A change on either flag therefore reaches the state register on the third rising clock edge after it appears at the pin.

Top module: `supply_guard`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs are mem_ce_n_o=1, mem_oe_n_o=1, mem_we_n_o=1, bus_drive_o=0 and bat_sel_o=0. The guard starts in the protected state.
- R2: In normal operation, each mem strobe equals the matching host strobe (all active low). bus_drive_o is 1 only when host_ce_n_i=0, host_oe_n_i=0 and host_we_n_i=1.
- R3: If supply_low_i rises while host_busy_i=0, all mem strobes are forced high and bus_drive_o goes to 0 on the third rising edge after the rise.
- R4: If host_busy_i=1 on the edge where the synchronized failure is first seen, the strobes keep passing. They are forced high on the first edge at which host_busy_i is sampled 0.
- R5: If host_busy_i stays 1, the strobes are forced high on rising edge 3+TWP after supply_low_i rises. They still pass on edge 3+TWP-1.
- R6: While protected, any host strobe pattern leaves mem_ce_n_o=1, mem_oe_n_o=1, mem_we_n_o=1 and bus_drive_o=0.
- R7: While protected and powered at least once, bat_sel_o rises on the third rising edge after batt_low_i rises.
- R8: bat_sel_o falls on the third rising edge after batt_low_i falls. The strobes stay forced high while supply_low_i is still 1.
- R9: After supply_low_i falls, access resumes on rising edge 3+TER. The strobes are still forced high on edge 3+TER-1.
- R10: If supply_low_i rises again during the recovery window, the guard returns to protection without enabling access. The next fall of supply_low_i starts a fresh full TER window.
- R11: After reset, bat_sel_o stays 0 even with batt_low_i=1, until supply_low_i has been seen low after synchronization.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_low_i | input | 1 | Comparator flag: supply below deselect threshold |
| batt_low_i | input | 1 | Comparator flag: supply below switchover threshold |
| host_ce_n_i | input | 1 | Host chip enable, active low |
| host_oe_n_i | input | 1 | Host output enable, active low |
| host_we_n_i | input | 1 | Host write enable, active low |
| host_busy_i | input | 1 | Host access cycle in progress |
| mem_ce_n_o | output | 1 | Gated chip enable to the array |
| mem_oe_n_o | output | 1 | Gated output enable to the array |
| mem_we_n_o | output | 1 | Gated write enable to the array |
| bus_drive_o | output | 1 | Data-bus output drive enable (0 = high impedance) |
| bat_sel_o | output | 1 | Retention power taken from the internal source |

## Verification
A controller stuck in a pass-through state shows up at once as host strobes reaching the array while the supply flag is set. This becomes visible three cycles after the flag rises. A wrong window count shows up as access returning one or more cycles early or late, relative to edge 3+TER, or as protection missing on edge 3+TWP. A wrong battery decision shows up on bat_sel_o three cycles after the switchover flag moves, or right after reset when the flag is already high.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_GRACE  = 3'd1,
    ST_PROT   = 3'd2,
    ST_BATT   = 3'd3,
    ST_RECOV  = 3'd4
  } sg_state_e;
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d_i[b];
        s2_q <= s1_q;
      end
    end
    assign q_o[b] = s2_q;
  end
endmodule

// File: rtl/sg_timer.sv
module sg_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr_i || (cnt_q != CMAX);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sg_fsm.sv
module sg_fsm
  import sg_pkg::*;
#(
  parameter int TWP = 8,
  parameter int TER = 16,
  parameter int CW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dsel_s_i,
  input  logic          bat_s_i,
  input  logic          busy_i,
  input  logic [CW-1:0] cnt_i,
  output logic          restart_o,
  output logic          acc_en_o,
  output logic          bat_sel_o
);
  localparam logic [CW-1:0] GRACE_LAST = CW'(TWP - 1);
  localparam logic [CW-1:0] RECOV_LAST = CW'(TER - 1);

  sg_state_e state_q, state_d;
  logic      powered_q, powered_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: if (dsel_s_i) state_d = busy_i ? ST_GRACE : ST_PROT;
      ST_GRACE:  if (!busy_i || cnt_i == GRACE_LAST) state_d = ST_PROT;
      ST_PROT: begin
        if (bat_s_i && powered_q) state_d = ST_BATT;
        else if (!dsel_s_i)       state_d = ST_RECOV;
      end
      ST_BATT:   if (!bat_s_i) state_d = ST_PROT;
      ST_RECOV: begin
        if (dsel_s_i)                 state_d = ST_PROT;
        else if (cnt_i == RECOV_LAST) state_d = ST_NORMAL;
      end
      default:   state_d = ST_PROT;
    endcase
  end

  assign powered_d = powered_q | ~dsel_s_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_PROT;
      powered_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      powered_q <= powered_d;
    end
  end

  assign restart_o = (state_d != state_q);
  assign acc_en_o  = (state_q == ST_NORMAL) || (state_q == ST_GRACE);
  assign bat_sel_o = (state_q == ST_BATT);

  // R5: the grace window never runs past its last cycle
  p_grace_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GRACE) |-> (cnt_i <= GRACE_LAST));

  // R3: failure seen with no access in flight closes access on the next edge
  p_idle_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NORMAL && dsel_s_i && !busy_i) |=> (state_q == ST_PROT));

  // R10: a new failure during recovery returns to protection
  p_recov_refail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECOV && dsel_s_i) |=> (state_q == ST_PROT));

  // R9: recovery ends only at its last counted cycle
  p_recov_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECOV && $past(state_q) == ST_RECOV && !acc_en_o) |-> (cnt_i != '0));

  // R11: battery is never selected before first power-up
  p_isolated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sel_o |-> powered_q);

  // R8: loss of the switchover flag leaves battery mode on the next edge
  p_batt_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BATT && !bat_s_i) |=> (state_q == ST_PROT));
endmodule

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int TWP = 8,
  parameter int TER = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low_i,
  input  logic batt_low_i,
  input  logic host_ce_n_i,
  input  logic host_oe_n_i,
  input  logic host_we_n_i,
  input  logic host_busy_i,
  output logic mem_ce_n_o,
  output logic mem_oe_n_o,
  output logic mem_we_n_o,
  output logic bus_drive_o,
  output logic bat_sel_o
);
  localparam int WMAX = (TWP > TER) ? TWP : TER;
  localparam int CW   = $clog2(WMAX + 1);

  logic          rs1_q, rs2_q, rst_sn;
  logic [1:0]    flags_s;
  logic [CW-1:0] cnt;
  logic          restart, acc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sn = rs2_q;

  sg_sync #(.N(2)) sync_i (
    .clk   (clk),
    .rst_n (rst_sn),
    .d_i   ({batt_low_i, supply_low_i}),
    .q_o   (flags_s)
  );

  sg_timer #(.CW(CW)) timer_i (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr_i (restart),
    .cnt_o (cnt)
  );

  sg_fsm #(.TWP(TWP), .TER(TER), .CW(CW)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_sn),
    .dsel_s_i  (flags_s[0]),
    .bat_s_i   (flags_s[1]),
    .busy_i    (host_busy_i),
    .cnt_i     (cnt),
    .restart_o (restart),
    .acc_en_o  (acc_en),
    .bat_sel_o (bat_sel_o)
  );

  assign mem_ce_n_o  = host_ce_n_i | ~acc_en;
  assign mem_oe_n_o  = host_oe_n_i | ~acc_en;
  assign mem_we_n_o  = host_we_n_i | ~acc_en;
  assign bus_drive_o = acc_en & ~host_ce_n_i & ~host_oe_n_i & host_we_n_i;

  // R2: the bus is driven only during a selected read
  p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    bus_drive_o |-> (!mem_ce_n_o && !mem_oe_n_o && mem_we_n_o));

  // R6: no write strobe can reach the array on battery
  p_no_write_batt_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    bat_sel_o |-> (mem_we_n_o && mem_ce_n_o && !bus_drive_o));
endmodule

// File: tb/supply_guard_tb_top.sv
module supply_guard_tb_top;
  localparam int TWP = 5;
  localparam int TER = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_low, batt_low, ce_n, oe_n, we_n, busy;
  logic m_ce_n, m_oe_n, m_we_n, drive, bsel;

  int n_chk = 0;
  int n_bad = 0;

  // {ce_n, oe_n, we_n, exp mem_ce_n, mem_oe_n, mem_we_n, bus_drive, bat_sel}
  localparam logic [7:0] VEC [8] = '{
    8'b000_00000, 8'b001_00110, 8'b010_01000, 8'b011_01100,
    8'b100_10000, 8'b101_10100, 8'b110_11000, 8'b111_11100
  };

  localparam logic [4:0] CLOSED = 5'b11100;
  localparam logic [4:0] CLOSED_BAT = 5'b11101;

  always #10 clk = ~clk;

  supply_guard #(.TWP(TWP), .TER(TER)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .supply_low_i (supply_low), .batt_low_i (batt_low),
    .host_ce_n_i (ce_n), .host_oe_n_i (oe_n), .host_we_n_i (we_n),
    .host_busy_i (busy),
    .mem_ce_n_o (m_ce_n), .mem_oe_n_o (m_oe_n), .mem_we_n_o (m_we_n),
    .bus_drive_o (drive), .bat_sel_o (bsel)
  );

  function automatic logic [4:0] outs();
    return {m_ce_n, m_oe_n, m_we_n, drive, bsel};
  endfunction

  task automatic chk(input string req, input logic [4:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, outs(), exp, $time);
    end
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host(input logic c, input logic o, input logic w);
    ce_n = c; oe_n = o; we_n = w;
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; supply_low = 1'b1; batt_low = 1'b1; busy = 1'b0;
    host(1'b1, 1'b1, 1'b1);
    edges(3);
    chk("R1 in reset", CLOSED);
    rst_n = 1'b1;
    edges(2);
    chk("R1 after release", CLOSED);
    host(1'b0, 1'b0, 1'b1);
    edges(6);
    chk("R11 battery isolated before first power", CLOSED);
    chk("R6 host read ignored while protected", CLOSED);

    // first power-up
    batt_low = 1'b0; supply_low = 1'b0;
    edges(3 + TER - 1);
    chk("R9 still protected at edge 3+TER-1", CLOSED);
    edges(1);
    chk("R9 access at edge 3+TER", 5'b00110);

    for (int i = 0; i < 8; i++) begin
      host(VEC[i][7], VEC[i][6], VEC[i][5]);
      #2;
      chk("R2 pass-through vector", VEC[i][4:0]);
      @(negedge clk);
    end

    // idle power failure
    host(1'b0, 1'b0, 1'b1); busy = 1'b0;
    supply_low = 1'b1;
    edges(2);
    chk("R3 open before third edge", 5'b00110);
    edges(1);
    chk("R3 closed on third edge", CLOSED);
    host(1'b0, 1'b1, 1'b0);
    #2;
    chk("R6 host write ignored while protected", CLOSED);
    host(1'b0, 1'b0, 1'b1);

    // re-failure during recovery
    supply_low = 1'b0;
    edges(5);
    supply_low = 1'b1;
    edges(TER);
    chk("R10 no access after re-failure", CLOSED);
    supply_low = 1'b0;
    edges(3 + TER - 1);
    chk("R10 fresh window still closed", CLOSED);
    edges(1);
    chk("R10 access after fresh window", 5'b00110);

    // in-flight write completes
    host(1'b0, 1'b1, 1'b0); busy = 1'b1;
    supply_low = 1'b1;
    edges(3);
    chk("R4 grace passes strobes", 5'b01000);
    edges(1);
    chk("R4 grace still passing", 5'b01000);
    busy = 1'b0;
    #2;
    chk("R4 open until busy sampled", 5'b01000);
    edges(1);
    chk("R4 closed after access ends", CLOSED);

    supply_low = 1'b0;
    edges(3 + TER);
    chk("R9 access resumes", 5'b01000);

    // in-flight write that overruns the window
    busy = 1'b1;
    supply_low = 1'b1;
    edges(3 + TWP - 1);
    chk("R5 still in grace at edge 3+TWP-1", 5'b01000);
    edges(1);
    chk("R5 forced protection at edge 3+TWP", CLOSED);
    busy = 1'b0;

    // battery switchover
    batt_low = 1'b1;
    edges(2);
    chk("R7 battery not yet selected", CLOSED);
    edges(1);
    chk("R7 battery selected", CLOSED_BAT);
    host(1'b0, 1'b1, 1'b0);
    #2;
    chk("R6 host write ignored on battery", CLOSED_BAT);
    host(1'b0, 1'b0, 1'b1);
    batt_low = 1'b0;
    edges(2);
    chk("R8 battery held before third edge", CLOSED_BAT);
    edges(1);
    chk("R8 battery released", CLOSED);
    edges(10);
    chk("R8 still protected while supply low", CLOSED);
    supply_low = 1'b0;
    edges(3 + TER);
    chk("R9 access after battery episode", 5'b00110);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule